// File: doc/BRIEF.md
# Set-Associative Translation Cache with Global Entries

This block keeps recently used linear-to-physical page translations for a paging unit so that most memory accesses skip the page-table walk. It is organised as eight sets of four ways. Bits 14..12 of the linear address pick the set, and bits 31..15 are the tag that is compared in every way of that set. A lookup carries the linear address and two access flags, write and user. It returns a hit together with the physical address in the same cycle, or it reports a miss. A miss sends the paging unit to the walker.

When the walk finishes, the walker installs the page-table entry it read, together with the flags of the access that caused the walk. Three maintenance inputs remove entries. The first clears every entry that is not marked global, which is the usual action on an address-space switch. The second clears everything. The third removes a single linear page, whether or not that page is global. Installs and removals take effect at the next rising clock edge.

Top module: `xlate_tlb`

## Requirements
- R1: After a synchronous active-high reset, every lookup misses until an entry is installed.
- R2: An install with present bit 0 of `up_pte` set writes an entry for the page `up_vpn`. Set = vpn[2:0], tag = vpn[19:3]. From the next edge on, a supervisor read of that page hits, and `lk_paddr` = {`up_pte`[31:12], `lk_addr`[11:0]}.
- R3: An install whose present bit 0 is clear changes nothing. A later lookup of that page still misses.
- R4: Installing a page that is already held overwrites the way that holds it. No page ever matches in two ways at once.
- R5: When the page is not held, the install takes the lowest-numbered invalid way of the set. If all four ways are valid, it takes the way named by that set's round-robin pointer. The pointer starts at way 0 and advances by one, wrapping, only after an install that used it.
- R6: A lookup with `lk_user`=1 hits only if user bit 2 of the stored entry is set. A lookup with `lk_write`=1 hits only if writable bit 1 is set and the entry is dirty. A failed permission check is reported as a miss.
- R7: An entry is dirty when dirty bit 6 of `up_pte` is set or when `up_write` was 1 at install. A write lookup to a clean entry therefore misses until the page is installed again.
- R8: `fl_nonglobal` clears every entry whose global bit 8 was clear at install. Entries with bit 8 set keep hitting.
- R9: `fl_all` clears every entry, global ones included.
- R10: `inv_valid` clears the entry, if any, that holds page `inv_vpn`, global or not. Other pages are not affected.
- R11: An install presented in the same cycle as any flush or invalidate is dropped, and it does not move the round-robin pointer. Flush and invalidate requests made in the same cycle all take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| lk_addr | input | 32 | Linear address to translate |
| lk_write | input | 1 | Lookup is for a write |
| lk_user | input | 1 | Lookup is made at user privilege |
| lk_hit | output | 1 | Translation found and permitted |
| lk_paddr | output | 32 | Physical address, valid when `lk_hit` is 1 |
| up_valid | input | 1 | Install request |
| up_vpn | input | 20 | Linear page number being installed |
| up_pte | input | 32 | Page-table entry from the walker |
| up_write | input | 1 | The walk was caused by a write |
| fl_nonglobal | input | 1 | Clear all non-global entries |
| fl_all | input | 1 | Clear all entries |
| inv_valid | input | 1 | Invalidate one page |
| inv_vpn | input | 20 | Linear page number to invalidate |

## Verification
The assertions assume that every control input is a clean 0 or 1 at every rising edge after reset. They also assume that the lookup inputs may change freely in any cycle, because a lookup never alters any state. The stimulus drives all inputs on the falling edge and returns every request strobe to 0 after a single cycle. It sends installs, flushes and invalidates together only in the cycles meant to exercise R11. This keeps each check tied to one known edge.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    localparam int LADDR_W    = 32;
    localparam int PAGE_SHIFT = 12;
    localparam int SET_BITS   = 3;
    localparam int NSETS      = 1 << SET_BITS;
    localparam int NWAYS      = 4;
    localparam int VPN_W      = LADDR_W - PAGE_SHIFT;
    localparam int TAG_W      = VPN_W - SET_BITS;
    localparam int PFN_W      = LADDR_W - PAGE_SHIFT;

    // bit positions inside a page-table entry
    localparam int PTE_PRESENT = 0;
    localparam int PTE_WRITE   = 1;
    localparam int PTE_USER    = 2;
    localparam int PTE_DIRTY   = 6;
    localparam int PTE_GLOBAL  = 8;

    typedef logic [SET_BITS-1:0] set_idx_t;
    typedef logic [TAG_W-1:0]    tag_t;

    typedef struct packed {
        logic             valid;
        logic             glob;
        logic             wr;
        logic             usr;
        logic             dirty;
        tag_t             tag;
        logic [PFN_W-1:0] pfn;
    } tlb_ent_t;

    function automatic set_idx_t vpn_set(input logic [VPN_W-1:0] vpn);
        return vpn[SET_BITS-1:0];
    endfunction

    function automatic tag_t vpn_tag(input logic [VPN_W-1:0] vpn);
        return vpn[VPN_W-1:SET_BITS];
    endfunction

    function automatic tlb_ent_t build_entry(input logic [VPN_W-1:0] vpn,
                                             input logic [LADDR_W-1:0] pte,
                                             input logic caused_by_write);
        tlb_ent_t e;
        e.valid = 1'b1;
        e.glob  = pte[PTE_GLOBAL];
        e.wr    = pte[PTE_WRITE];
        e.usr   = pte[PTE_USER];
        e.dirty = pte[PTE_DIRTY] | caused_by_write;
        e.tag   = vpn_tag(vpn);
        e.pfn   = pte[LADDR_W-1:PAGE_SHIFT];
        return e;
    endfunction

endpackage

// File: rtl/tlb_match.sv
module tlb_match
    import tlb_pkg::*;
#(
    parameter int WAYS = NWAYS
) (
    input  tlb_ent_t [WAYS-1:0] row_i,
    input  tag_t                tag_i,
    output logic [WAYS-1:0]     hit_o
);

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign hit_o[w] = row_i[w].valid && (row_i[w].tag == tag_i);
    end

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim
    import tlb_pkg::*;
#(
    parameter int WAYS = NWAYS
) (
    input  tlb_ent_t [WAYS-1:0]      row_i,
    input  logic [WAYS-1:0]          match_i,
    input  logic [$clog2(WAYS)-1:0]  ptr_i,
    output logic [$clog2(WAYS)-1:0]  way_o,
    output logic                     use_ptr_o
);

    localparam int PW = $clog2(WAYS);

    logic found_match;
    logic found_free;
    logic [PW-1:0] match_way;
    logic [PW-1:0] free_way;

    always_comb begin
        found_match = 1'b0;
        found_free  = 1'b0;
        match_way   = '0;
        free_way    = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (match_i[w] && !found_match) begin
                found_match = 1'b1;
                match_way   = PW'(w);
            end
            if (!row_i[w].valid && !found_free) begin
                found_free = 1'b1;
                free_way   = PW'(w);
            end
        end
        if (found_match) begin
            way_o     = match_way;
            use_ptr_o = 1'b0;
        end else if (found_free) begin
            way_o     = free_way;
            use_ptr_o = 1'b0;
        end else begin
            way_o     = ptr_i;
            use_ptr_o = 1'b1;
        end
    end

endmodule

// File: rtl/tlb_store.sv
module tlb_store
    import tlb_pkg::*;
#(
    parameter int SETS = NSETS,
    parameter int WAYS = NWAYS
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                inst_en,
    input  logic [$clog2(SETS)-1:0]             inst_set,
    input  logic [$clog2(WAYS)-1:0]             inst_way,
    input  tlb_ent_t                            inst_ent,
    input  logic                                adv_en,
    input  logic                                flush_ng,
    input  logic                                flush_all,
    input  logic                                inv_en,
    input  logic [$clog2(SETS)-1:0]             inv_set,
    input  logic [WAYS-1:0]                     inv_hit,
    output tlb_ent_t [SETS-1:0][WAYS-1:0]       tbl_o,
    output logic [SETS-1:0][$clog2(WAYS)-1:0]   ptr_o
);

    localparam int PW = $clog2(WAYS);
    localparam int SW = $clog2(SETS);

    tlb_ent_t [SETS-1:0][WAYS-1:0]  tbl_q;
    logic [SETS-1:0][PW-1:0]        ptr_q;

    for (genvar s = 0; s < SETS; s++) begin : g_set
        logic this_inst;
        logic this_inv;
        assign this_inst = inst_en && (inst_set == SW'(s));
        assign this_inv  = inv_en  && (inv_set  == SW'(s));

        for (genvar w = 0; w < WAYS; w++) begin : g_way
            logic drop;
            assign drop = flush_all
                       || (flush_ng && !tbl_q[s][w].glob)
                       || (this_inv && inv_hit[w]);

            always_ff @(posedge clk) begin
                if (rst) begin
                    tbl_q[s][w] <= '0;
                end else if (drop) begin
                    tbl_q[s][w].valid <= 1'b0;
                end else if (this_inst && (inst_way == PW'(w))) begin
                    tbl_q[s][w] <= inst_ent;
                end
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                ptr_q[s] <= '0;
            end else if (this_inst && adv_en) begin
                ptr_q[s] <= (ptr_q[s] == PW'(WAYS - 1)) ? '0 : ptr_q[s] + 1'b1;
            end
        end
    end

    assign tbl_o = tbl_q;
    assign ptr_o = ptr_q;

endmodule

// File: rtl/xlate_tlb.sv
module xlate_tlb
    import tlb_pkg::*;
#(
    parameter int SETS = NSETS,
    parameter int WAYS = NWAYS
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [LADDR_W-1:0]   lk_addr,
    input  logic                 lk_write,
    input  logic                 lk_user,
    output logic                 lk_hit,
    output logic [LADDR_W-1:0]   lk_paddr,
    input  logic                 up_valid,
    input  logic [VPN_W-1:0]     up_vpn,
    input  logic [LADDR_W-1:0]   up_pte,
    input  logic                 up_write,
    input  logic                 fl_nonglobal,
    input  logic                 fl_all,
    input  logic                 inv_valid,
    input  logic [VPN_W-1:0]     inv_vpn
);

    localparam int PW = $clog2(WAYS);

    tlb_ent_t [SETS-1:0][WAYS-1:0]  tbl;
    logic [SETS-1:0][PW-1:0]        ptr;

    // lookup path
    logic [VPN_W-1:0]     lk_vpn;
    set_idx_t             lk_set;
    logic [WAYS-1:0]      lk_match;
    tlb_ent_t             lk_ent;
    logic                 perm_ok;

    assign lk_vpn = lk_addr[LADDR_W-1:PAGE_SHIFT];
    assign lk_set = vpn_set(lk_vpn);

    tlb_match #(.WAYS(WAYS)) u_lk_match (
        .row_i (tbl[lk_set]),
        .tag_i (vpn_tag(lk_vpn)),
        .hit_o (lk_match)
    );

    always_comb begin
        lk_ent = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (lk_match[w]) lk_ent = lk_ent | tbl[lk_set][w];
        end
    end

    assign perm_ok  = (!lk_user  || lk_ent.usr)
                   && (!lk_write || (lk_ent.wr && lk_ent.dirty));
    assign lk_hit   = (|lk_match) && perm_ok;
    assign lk_paddr = {lk_ent.pfn, lk_addr[PAGE_SHIFT-1:0]};

    // install path
    set_idx_t             up_set;
    logic [WAYS-1:0]      up_match;
    logic [PW-1:0]        up_way;
    logic                 up_use_ptr;
    logic                 up_go;
    logic                 unused_pte;

    assign up_set     = vpn_set(up_vpn);
    assign unused_pte = ^{up_pte[PAGE_SHIFT-1:PTE_GLOBAL+1], up_pte[PTE_DIRTY+1],
                          up_pte[PTE_DIRTY-1:PTE_USER+1]};

    tlb_match #(.WAYS(WAYS)) u_up_match (
        .row_i (tbl[up_set]),
        .tag_i (vpn_tag(up_vpn)),
        .hit_o (up_match)
    );

    tlb_victim #(.WAYS(WAYS)) u_victim (
        .row_i     (tbl[up_set]),
        .match_i   (up_match),
        .ptr_i     (ptr[up_set]),
        .way_o     (up_way),
        .use_ptr_o (up_use_ptr)
    );

    assign up_go = up_valid && up_pte[PTE_PRESENT]
                && !fl_nonglobal && !fl_all && !inv_valid;

    // invalidate path
    set_idx_t             inv_set;
    logic [WAYS-1:0]      inv_match;

    assign inv_set = vpn_set(inv_vpn);

    tlb_match #(.WAYS(WAYS)) u_inv_match (
        .row_i (tbl[inv_set]),
        .tag_i (vpn_tag(inv_vpn)),
        .hit_o (inv_match)
    );

    tlb_store #(.SETS(SETS), .WAYS(WAYS)) u_store (
        .clk       (clk),
        .rst       (rst),
        .inst_en   (up_go),
        .inst_set  (up_set),
        .inst_way  (up_way),
        .inst_ent  (build_entry(up_vpn, up_pte, up_write)),
        .adv_en    (up_use_ptr),
        .flush_ng  (fl_nonglobal),
        .flush_all (fl_all),
        .inv_en    (inv_valid),
        .inv_set   (inv_set),
        .inv_hit   (inv_match),
        .tbl_o     (tbl),
        .ptr_o     (ptr)
    );

endmodule

// File: rtl/xlate_tlb_chk.sv
module xlate_tlb_chk
    import tlb_pkg::*;
#(
    parameter int WAYS = NWAYS
) (
    input logic              clk,
    input logic              rst,
    input logic [VPN_W-1:0]  lk_vpn,
    input logic              lk_write,
    input logic              lk_user,
    input logic              lk_hit,
    input logic [WAYS-1:0]   lk_match,
    input logic              up_valid,
    input logic              up_present,
    input logic [VPN_W-1:0]  up_vpn,
    input logic              fl_ng,
    input logic              fl_all,
    input logic              inv_valid,
    input logic [VPN_W-1:0]  inv_vpn
);

    AST_INSTALL_VISIBLE: assert property (@(posedge clk) disable iff (rst)
        (up_valid && up_present && !fl_ng && !fl_all && !inv_valid)
        |=> (lk_vpn != $past(up_vpn)) || lk_write || lk_user || lk_hit); // R2

    AST_NO_DUP_WAY: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lk_match)); // R4

    AST_FULL_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
        fl_all |=> !lk_hit); // R9

    AST_PAGE_INV_GONE: assert property (@(posedge clk) disable iff (rst)
        inv_valid |=> (lk_vpn != $past(inv_vpn)) || !lk_hit); // R10

    AST_ABSENT_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (up_valid && !up_present && !$past(up_valid) && (lk_vpn == up_vpn))
        |=> !lk_hit || (lk_vpn != $past(up_vpn)) || $past(lk_hit)); // R3

endmodule

bind xlate_tlb xlate_tlb_chk #(.WAYS(WAYS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .lk_vpn     (lk_addr[31:12]),
    .lk_write   (lk_write),
    .lk_user    (lk_user),
    .lk_hit     (lk_hit),
    .lk_match   (lk_match),
    .up_valid   (up_valid),
    .up_present (up_pte[0]),
    .up_vpn     (up_vpn),
    .fl_ng      (fl_nonglobal),
    .fl_all     (fl_all),
    .inv_valid  (inv_valid),
    .inv_vpn    (inv_vpn)
);

// File: tb/test_xlate_tlb.sv
module test_xlate_tlb;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = CLK_PERIOD / 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] lk_addr = '0;
    logic        lk_write = 1'b0;
    logic        lk_user = 1'b0;
    logic        lk_hit;
    logic [31:0] lk_paddr;
    logic        up_valid = 1'b0;
    logic [19:0] up_vpn = '0;
    logic [31:0] up_pte = '0;
    logic        up_write = 1'b0;
    logic        fl_nonglobal = 1'b0;
    logic        fl_all = 1'b0;
    logic        inv_valid = 1'b0;
    logic [19:0] inv_vpn = '0;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(HALF) clk = ~clk;

    xlate_tlb i_xlate_tlb (
        .clk(clk), .rst(rst),
        .lk_addr(lk_addr), .lk_write(lk_write), .lk_user(lk_user),
        .lk_hit(lk_hit), .lk_paddr(lk_paddr),
        .up_valid(up_valid), .up_vpn(up_vpn), .up_pte(up_pte), .up_write(up_write),
        .fl_nonglobal(fl_nonglobal), .fl_all(fl_all),
        .inv_valid(inv_valid), .inv_vpn(inv_vpn)
    );

    // behavioural reference: per-slot records held in integers
    int m_v[8][4], m_g[8][4], m_wr[8][4], m_us[8][4], m_d[8][4];
    int m_tag[8][4], m_pfn[8][4];
    int m_ptr[8];

    task automatic model_reset();
        foreach (m_v[s, w]) m_v[s][w] = 0;
        foreach (m_ptr[s]) m_ptr[s] = 0;
    endtask

    task automatic model_look(output bit hit, output logic [31:0] pa);
        int s;
        int t;
        s   = int'(lk_addr[14:12]);
        t   = int'(lk_addr[31:15]);
        hit = 0;
        pa  = '0;
        for (int w = 0; w < 4; w++) begin
            if (m_v[s][w] != 0 && m_tag[s][w] == t) begin
                hit = (!lk_user || m_us[s][w] != 0)
                   && (!lk_write || (m_wr[s][w] != 0 && m_d[s][w] != 0));
                pa  = {m_pfn[s][w][19:0], lk_addr[11:0]};
            end
        end
    endtask

    task automatic model_edge();
        int s;
        int t;
        int way;
        if (rst) begin
            model_reset();
            return;
        end
        if (fl_all) foreach (m_v[a, b]) m_v[a][b] = 0;
        if (fl_nonglobal) foreach (m_v[a, b]) if (m_g[a][b] == 0) m_v[a][b] = 0;
        if (inv_valid) begin
            s = int'(inv_vpn[2:0]);
            t = int'(inv_vpn[19:3]);
            for (int w = 0; w < 4; w++) if (m_tag[s][w] == t) m_v[s][w] = 0;
        end
        if (up_valid && up_pte[0] && !fl_all && !fl_nonglobal && !inv_valid) begin
            s = int'(up_vpn[2:0]);
            t = int'(up_vpn[19:3]);
            way = -1;
            for (int w = 0; w < 4; w++) if (way < 0 && m_v[s][w] != 0 && m_tag[s][w] == t) way = w;
            for (int w = 0; w < 4; w++) if (way < 0 && m_v[s][w] == 0) way = w;
            if (way < 0) begin
                way = m_ptr[s];
                m_ptr[s] = (m_ptr[s] + 1) % 4;
            end
            m_v[s][way]   = 1;
            m_g[s][way]   = int'(up_pte[8]);
            m_wr[s][way]  = int'(up_pte[1]);
            m_us[s][way]  = int'(up_pte[2]);
            m_d[s][way]   = int'(up_pte[6] | up_write);
            m_tag[s][way] = t;
            m_pfn[s][way] = int'(up_pte[31:12]);
        end
    endtask

    // one clock: compare before the edge, advance the model at the edge,
    // release the one-cycle strobes at the following falling edge
    task automatic tick(input string tag);
        bit          e_hit;
        logic [31:0] e_pa;
        #(HALF - 1);
        model_look(e_hit, e_pa);
        checks++;
        if (lk_hit !== e_hit) begin
            fails++;
            $display("FAIL %s: addr=%h hit=%0b expected %0b", tag, lk_addr, lk_hit, e_hit);
        end else if (e_hit) begin
            checks++;
            if (lk_paddr !== e_pa) begin
                fails++;
                $display("FAIL %s: addr=%h paddr=%h expected %h", tag, lk_addr, lk_paddr, e_pa);
            end
        end
        @(posedge clk);
        model_edge();
        @(negedge clk);
        up_valid = 0; fl_nonglobal = 0; fl_all = 0; inv_valid = 0; up_write = 0;
    endtask

    task automatic look(input logic [31:0] a, input bit w, input bit u, input string tag);
        lk_addr = a; lk_write = w; lk_user = u;
        tick(tag);
    endtask

    task automatic install(input logic [19:0] vpn, input logic [31:0] pte, input bit w);
        up_valid = 1; up_vpn = vpn; up_pte = pte; up_write = w;
    endtask

    localparam logic [31:0] P = 32'h1, RW = 32'h2, US = 32'h4, D = 32'h40, G = 32'h100;

    initial begin
        model_reset();
        rst = 1;
        @(negedge clk);
        tick("R1");
        tick("R1");
        rst = 0;
        look(32'h0000_5123, 0, 0, "R1");
        look(32'h0000_0000, 0, 1, "R1");

        // basic install and translation
        install(20'h00005, 32'h0ABC_D000 | P | RW | US, 0);
        look(32'h0000_5123, 0, 0, "R2");
        look(32'h0000_5123, 0, 0, "R2");
        look(32'h0000_5FFF, 0, 1, "R2");
        look(32'h0000_D123, 0, 0, "R2");

        // dirty handling
        look(32'h0000_5010, 1, 0, "R7");
        install(20'h00005, 32'h0ABC_D000 | P | RW | US, 1);
        tick("R7");
        look(32'h0000_5010, 1, 0, "R7");
        install(20'h00031, 32'h0222_2000 | P | RW | D, 0);
        look(32'h0003_1444, 1, 0, "R7");
        look(32'h0003_1444, 1, 0, "R7");

        // not-present install is ignored
        install(20'h00033, 32'h0555_5000 | RW | US, 0);
        look(32'h0003_3000, 0, 0, "R3");
        look(32'h0003_3000, 0, 0, "R3");

        // permissions
        look(32'h0003_1444, 1, 1, "R6");
        look(32'h0003_1444, 0, 1, "R6");
        install(20'h00042, 32'h0333_3000 | P | US | D, 0);
        tick("R6");
        look(32'h0004_2004, 1, 1, "R6");
        look(32'h0004_2004, 0, 1, "R6");

        // refresh of a held page
        install(20'h00005, 32'h0777_7000 | P | US, 0);
        tick("R4");
        look(32'h0000_5ABC, 0, 0, "R4");
        look(32'h0000_5ABC, 0, 1, "R4");

        // victim choice in set 0
        for (int k = 1; k <= 4; k++) begin
            install(20'(k * 8), 32'(k) << 12 | P, 0);
            tick("R5");
        end
        for (int k = 1; k <= 4; k++) look(32'(k * 8) << 12, 0, 0, "R5");
        install(20'h00028, 32'h0000_5000 | P, 0);
        tick("R5");
        install(20'h00030, 32'h0000_6000 | P, 0);
        tick("R5");
        for (int k = 1; k <= 6; k++) look(32'(k * 8) << 12, 0, 0, "R5");
        inv_valid = 1; inv_vpn = 20'h00020;
        tick("R5");
        install(20'h00038, 32'h0000_7000 | P, 0);
        tick("R5");
        for (int k = 1; k <= 7; k++) look(32'(k * 8) << 12, 0, 0, "R5");

        // global survival and single-page invalidate
        install(20'h00061, 32'h0888_8000 | P | G, 0);
        tick("R8");
        install(20'h00062, 32'h0999_9000 | P | G, 0);
        tick("R8");
        fl_nonglobal = 1;
        look(32'h0006_1000, 0, 0, "R8");
        look(32'h0006_1000, 0, 0, "R8");
        look(32'h0006_2000, 0, 0, "R8");
        look(32'h0000_5000, 0, 0, "R8");
        look(32'h0003_1000, 0, 0, "R8");
        inv_valid = 1; inv_vpn = 20'h00061;
        look(32'h0006_1000, 0, 0, "R10");
        look(32'h0006_1000, 0, 0, "R10");
        look(32'h0006_2000, 0, 0, "R10");

        // install blocked by a simultaneous flush or invalidate
        install(20'h00070, 32'h0AAA_A000 | P, 0);
        fl_nonglobal = 1;
        tick("R11");
        look(32'h0007_0000, 0, 0, "R11");
        install(20'h00071, 32'h0BBB_B000 | P, 0);
        inv_valid = 1; inv_vpn = 20'h00099;
        tick("R11");
        look(32'h0007_1000, 0, 0, "R11");
        install(20'h00072, 32'h0CCC_C000 | P, 0);
        fl_all = 1; inv_valid = 1; inv_vpn = 20'h00062;
        tick("R11");
        look(32'h0007_2000, 0, 0, "R11");

        // full flush
        install(20'h00062, 32'h0999_9000 | P | G, 0);
        tick("R9");
        install(20'h00005, 32'h0123_4000 | P, 0);
        tick("R9");
        look(32'h0006_2000, 0, 0, "R9");
        fl_all = 1;
        look(32'h0000_5000, 0, 0, "R9");
        look(32'h0006_2000, 0, 0, "R9");
        look(32'h0000_5000, 0, 0, "R9");

        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule